// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is the data-memory stage of a small pipelined 32-bit processor. It holds a direct-mapped cache in front of a word-organised backing memory and serves 32-bit loads and stores at byte addresses. The cache has four lines. Each line holds four 32-bit words, a 26-bit tag and a valid bit, which is 155 bits per line.

A load that finds its line present returns the word in the same cycle. A load that misses raises `miss` for a fixed number of cycles (three by default). The pipeline holds its address steady during those cycles while the whole four-word block is copied from the backing memory into the line. Every store goes straight to the backing memory, so the memory holds the right values when a program ends. A store also refreshes the cached copy when its line is present, and allocates nothing when the line is absent.

The request pins are plain level signals and not a valid/ready stream. A stalled pipeline simply repeats its request, so the cache needs no back-pressure at its edge. The cache's stall request is merged with the pipeline's other stall sources to form `stall`.

Top module: `dcache_wt`

## Requirements
- R1: While `clear` is high, and after it is released, every line is invalid, so the first load to any address misses.
- R2: Byte address bits [5:4] select the line, bits [3:2] select the word in the line, and bits [31:6] form the tag. Two addresses with the same line bits but different tags evict each other.
- R3: A load (`re`=1, `we`=0) whose line is valid with a matching tag returns the addressed word on `rdata` in the same cycle, with `miss`=0.
- R4: A load that misses holds `miss`=1 for exactly 3 consecutive cycles while the address is held. In the cycle after that, `miss`=0 and `rdata` carries the word from the backing memory.
- R5: A refill loads all four words of the block, so loads to the other three words of that block then hit.
- R6: Every store writes `wdata` into the backing-memory word at address bits [9:2] at the clock edge, whether or not the line is present. A store never raises `miss`.
- R7: A store whose line is present updates the cached word at the same edge, so a later load hits and returns the new value.
- R8: A store whose line is absent leaves the cache unchanged, so a later load to that address still misses.
- R9: `rdata` is zero whenever no load hits: when `re`=0, when `we`=1, or while `miss`=1.
- R10: `stall` is high whenever `miss` or `ext_stall` is high, and low otherwise.
- R11: When `re` and `we` are both high, the access is a store: memory is written, `miss` stays low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clear | input | 1 | Asynchronous active-high clear; invalidates all lines |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data |
| re | input | 1 | Load request |
| we | input | 1 | Store request |
| ext_stall | input | 1 | Stall request from other pipeline hazards |
| rdata | output | 32 | Load data, zero when no load hits |
| miss | output | 1 | Cache refill in progress |
| stall | output | 1 | Combined pipeline stall |

## Verification
A wrong valid bit or tag in a line shows up at the ports at once. The next load to that line either raises `miss` when it should not, or skips the three-cycle stall and returns a stale word in the same cycle. A wrong refill word or a lost store-hit update stays hidden until a load touches that word. The sweep therefore reads every word of every block after each kind of write. A store that never reached the backing memory shows up only after its line has been evicted and reloaded. The bench forces those evictions with conflicting tags and then checks the refilled values.

// File: rtl/dcache_wt_pkg.sv
package dcache_wt_pkg;
  localparam int DC_WORD_W = 32;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } dc_acc_e;
endpackage

// File: rtl/dc_line_store.sv
module dc_line_store #(
  parameter int LINES = 4,
  parameter int WPL   = 4,
  parameter int TAG_W = 26,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WPL),
  localparam int LW    = WPL * DW
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [LW-1:0]    fill_data,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [OFF_W-1:0] upd_off,
  input  logic [DW-1:0]    upd_data,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [LW-1:0]    rd_data
);
  logic             vld_q [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LW-1:0]    dat_q [LINES];

  // word 0 sits in the most significant slice of a line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        dat_q[g] <= '0;
      end else if (fill_en && fill_idx == GI) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= fill_tag;
        dat_q[g] <= fill_data;
      end else if (upd_en && upd_idx == GI) begin
        dat_q[g][(WPL-1-int'(upd_off))*DW +: DW] <= upd_data;
      end
    end
  end

  always_comb begin
    rd_valid = vld_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_data  = dat_q[rd_idx];
  end
endmodule

// File: rtl/dc_backing_mem.sv
module dc_backing_mem #(
  parameter int DW        = 32,
  parameter int MEM_WORDS = 256,
  parameter int WPL       = 4,
  localparam int MA_W  = $clog2(MEM_WORDS),
  localparam int OFF_W = $clog2(WPL),
  localparam int BA_W  = MA_W - OFF_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MA_W-1:0]   waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [BA_W-1:0]   blk,
  output logic [WPL*DW-1:0] blk_data
);
  logic [DW-1:0] mem_q [MEM_WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  for (genvar k = 0; k < WPL; k++) begin : g_rd
    localparam logic [OFF_W-1:0] KO = OFF_W'(k);
    assign blk_data[(WPL-1-k)*DW +: DW] = mem_q[{blk, KO}];
  end
endmodule

// File: rtl/dc_miss_ctrl.sv
module dc_miss_ctrl
  import dcache_wt_pkg::*;
#(
  parameter int MISS_CYCLES = 3,
  localparam int CNT_W = $clog2(MISS_CYCLES + 1)
) (
  input  logic clk,
  input  logic clear,
  input  logic re,
  input  logic we,
  input  logic hit,
  output logic miss,
  output logic fill_en,
  output logic upd_en,
  output logic mem_we
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  logic             active;
  logic             last;
  dc_acc_e          acc;

  always_comb begin
    if (we)      acc = ACC_STORE;
    else if (re) acc = ACC_LOAD;
    else         acc = ACC_IDLE;
  end

  assign busy   = (cnt_q != '0);
  assign active = busy || (acc == ACC_LOAD && !hit);
  assign last   = active && (cnt_q == CNT_W'(MISS_CYCLES - 1));

  always_ff @(posedge clk or posedge clear) begin
    if (clear)       cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  assign miss    = active;
  assign fill_en = last;
  assign mem_we  = (acc == ACC_STORE) && !busy;
  assign upd_en  = mem_we && hit;
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int AW          = 32,
  parameter int LINES       = 4,
  parameter int WPL         = 4,
  parameter int MEM_WORDS   = 256,
  parameter int MISS_CYCLES = 3
) (
  input  logic        clk,
  input  logic        clear,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        re,
  input  logic        we,
  input  logic        ext_stall,
  output logic [31:0] rdata,
  output logic        miss,
  output logic        stall
);
  localparam int DW    = dcache_wt_pkg::DC_WORD_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WPL);
  localparam int TAG_W = AW - 2 - IDX_W - OFF_W;
  localparam int MA_W  = $clog2(MEM_WORDS);
  localparam int BA_W  = MA_W - OFF_W;
  localparam int LW    = WPL * DW;

  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [TAG_W-1:0] tag;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [LW-1:0]    rd_line;
  logic [LW-1:0]    blk_data;
  logic             hit;
  logic             fill_en, upd_en, mem_we;
  logic [DW-1:0]    word_sel;
  logic [1:0]       unused_lsb;

  assign unused_lsb = addr[1:0];
  assign idx = addr[2+OFF_W +: IDX_W];
  assign off = addr[2 +: OFF_W];
  assign tag = addr[AW-1 -: TAG_W];

  dc_line_store #(.LINES(LINES), .WPL(WPL), .TAG_W(TAG_W), .DW(DW)) lines_i (
    .clk(clk), .clear(clear), .rd_idx(idx),
    .fill_en(fill_en), .fill_idx(idx), .fill_tag(tag), .fill_data(blk_data),
    .upd_en(upd_en), .upd_idx(idx), .upd_off(off), .upd_data(wdata),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_line)
  );

  dc_backing_mem #(.DW(DW), .MEM_WORDS(MEM_WORDS), .WPL(WPL)) mem_i (
    .clk(clk), .we(mem_we), .waddr(addr[2 +: MA_W]), .wdata(wdata),
    .blk(addr[2+OFF_W +: BA_W]), .blk_data(blk_data)
  );

  assign hit = rd_valid && (rd_tag == tag);

  dc_miss_ctrl #(.MISS_CYCLES(MISS_CYCLES)) ctrl_i (
    .clk(clk), .clear(clear), .re(re), .we(we), .hit(hit),
    .miss(miss), .fill_en(fill_en), .upd_en(upd_en), .mem_we(mem_we)
  );

  always_comb begin
    word_sel = rd_line[(WPL-1-int'(off))*DW +: DW];
    rdata    = (re && !we && hit && !miss) ? word_sel : '0;
  end

  assign stall = miss || ext_stall;
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
  parameter int MISS_CYCLES = 3
) (
  input logic        clk,
  input logic        clear,
  input logic        re,
  input logic        we,
  input logic        miss,
  input logic [31:0] rdata
);
  logic [7:0] run_q;

  always_ff @(posedge clk or posedge clear) begin
    if (clear)     run_q <= '0;
    else if (miss) run_q <= run_q + 8'd1;
    else           run_q <= '0;
  end

  // R4: a stall never runs longer than the refill window
  a_r4_miss_max: assert property (@(posedge clk) disable iff (clear)
    run_q <= 8'(MISS_CYCLES));

  // R4: every stall that ends has lasted the full window
  a_r4_miss_exact: assert property (@(posedge clk) disable iff (clear)
    $fell(miss) |-> run_q == 8'(MISS_CYCLES));

  // R9: no load data while a refill is in progress
  a_r9_zero_on_miss: assert property (@(posedge clk) disable iff (clear)
    miss |-> rdata == 32'd0);

  // R9: no load data without a load request
  a_r9_zero_idle: assert property (@(posedge clk) disable iff (clear)
    (!re || we) && !miss |-> rdata == 32'd0);

  // R6: a store outside a refill never starts a stall
  a_r6_store_no_stall: assert property (@(posedge clk) disable iff (clear)
    we && !$past(miss) |-> !miss);
endmodule

bind dcache_wt dcache_wt_chk #(.MISS_CYCLES(MISS_CYCLES)) chk_i (
  .clk(clk), .clear(clear), .re(re), .we(we), .miss(miss), .rdata(rdata)
);

// File: tb/dcache_wt_tb_top.sv
module dcache_wt_tb_top;
  localparam int P = 10;

  logic        clk = 1'b0;
  logic        clear = 1'b1;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic        we = 1'b0;
  logic        ext_stall = 1'b0;
  logic [31:0] rdata;
  logic        miss;
  logic        stall;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_mem [256];
  bit          mv [4];
  logic [25:0] mt [4];

  always #(P/2) clk = ~clk;

  dcache_wt dut_i (
    .clk(clk), .clear(clear), .addr(addr), .wdata(wdata), .re(re), .we(we),
    .ext_stall(ext_stall), .rdata(rdata), .miss(miss), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h0101_0101) ^ salt ^ (32'(i) << 20);
  endfunction

  function automatic bit model_hit(input logic [31:0] a);
    return mv[a[5:4]] && mt[a[5:4]] == a[31:6];
  endfunction

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; re = 1'b0;
    #(P/4);
    chk(miss == 1'b0, req, 32'(miss), 32'd0);
    exp_mem[a[9:2]] = d;
  endtask

  task automatic do_load(input logic [31:0] a, input string req);
    logic [31:0] exp;
    int n;
    @(negedge clk);
    addr = a; re = 1'b1; we = 1'b0;
    #(P/4);
    exp = exp_mem[a[9:2]];
    if (model_hit(a)) begin
      chk(miss == 1'b0, req, 32'(miss), 32'd0);
      chk(rdata == exp, req, rdata, exp);
    end else begin
      chk(stall == 1'b1, "R10", 32'(stall), 32'd1);
      chk(rdata == 32'd0, "R9", rdata, 32'd0);
      n = 0;
      while (miss === 1'b1 && n < 8) begin
        n++;
        @(negedge clk);
        #(P/4);
      end
      chk(n == 3, req, 32'(n), 32'd3);
      chk(rdata == exp, req, rdata, exp);
      mv[a[5:4]] = 1'b1;
      mt[a[5:4]] = a[31:6];
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    re = 1'b0; we = 1'b0;
  endtask

  initial begin
    #(P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    #(P/4);
    chk(miss == 1'b0, "R1 reset miss", 32'(miss), 32'd0);
    chk(rdata == 32'd0, "R9 reset rdata", rdata, 32'd0);
    chk(stall == 1'b0, "R10 reset stall", 32'(stall), 32'd0);
    @(negedge clk);
    clear = 1'b0;

    // R6: fill backing memory through stores that all miss the cache
    for (int i = 0; i < 256; i++) do_store(32'(i * 4), pat(i, 32'hA5C3_0000), "R6");

    // R4 R5 R2: sweep all blocks, word 0 first, then the rest hit
    for (int b = 0; b < 64; b++)
      for (int w = 0; w < 4; w++) do_load(32'(b * 16 + w * 4), "R5");
    // second pass, different order and block stride
    for (int s = 0; s < 64; s++)
      for (int w = 3; w >= 0; w--) do_load(32'(((s * 5) % 64) * 16 + w * 4), "R4");

    // R7 store hit, then R6 write-through seen after eviction
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = 32'((10 + i) * 16 + 8);
      do_load(a, "R3");
      do_store(a, pat(i, 32'h5EED_0077), "R7");
      do_load(a, "R7");
      do_load(a + 32'd4, "R7");
      do_load(a + 32'd64, "R2");
      do_load(a, "R6");
    end

    // R8: store miss allocates nothing
    do_load(32'd320 + 32'd64, "R8");
    do_store(32'd320 + 32'd4, 32'hDEAD_BEEF, "R8");
    chk(!model_hit(32'd324), "R8 model", 32'd0, 32'd0);
    do_load(32'd324, "R8");

    // R2: upper tag bits distinguish addresses that share a memory word
    do_load(32'd100, "R3");
    do_load(32'h0001_0064, "R2");
    do_load(32'd100, "R2");

    // R11: simultaneous request is a store
    do_load(32'd200, "R3");
    @(negedge clk);
    addr = 32'd200; wdata = 32'h1234_5678; re = 1'b1; we = 1'b1;
    #(P/4);
    chk(miss == 1'b0, "R11 miss", 32'(miss), 32'd0);
    chk(rdata == 32'd0, "R11 rdata", rdata, 32'd0);
    exp_mem[200 >> 2] = 32'h1234_5678;
    do_load(32'd200, "R11");

    // R9 idle output, R10 external stall
    @(negedge clk);
    re = 1'b0; we = 1'b0; addr = 32'd200; ext_stall = 1'b1;
    #(P/4);
    chk(rdata == 32'd0, "R9 idle", rdata, 32'd0);
    chk(stall == 1'b1, "R10 ext", 32'(stall), 32'd1);
    chk(miss == 1'b0, "R10 miss", 32'(miss), 32'd0);
    @(negedge clk);
    ext_stall = 1'b0;
    #(P/4);
    chk(stall == 1'b0, "R10 none", 32'(stall), 32'd0);

    // R1: clear mid-run invalidates every line
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; end
    for (int i = 0; i < 4; i++) do_load(32'(640 + i * 16), "R1");
    go_idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule